// File: doc/BRIEF.md
# Multi-Target Serial Tuning-State Programmer

This block sits between on-chip control logic and a group of tuning-state receivers that share one three-wire serial bus. A requester hands over a target index, a 5-bit tuning state and a standby flag on a valid/ready command port. The block packs these into an 8-bit word. It then produces the enable, serial clock and serial data waveforms, and it pulses `done` when the transfer has finished. Every minimum interval on the bus is a parameter counted in system clock cycles. The integrator sets each one to the nanosecond limit divided by the system clock period, rounded up. These intervals are: enable rise to first clock rise, clock high time, clock low time, last clock fall to enable fall, and the enable-low gap between frames.

Two bus-sharing schemes are chosen at elaboration time by `SIMUL`. In the sequential scheme there is one shared data line and one enable per target. Only the addressed target is enabled, so targets change state one after another. In the simultaneous scheme there is one common enable and one data line per target. The block keeps the last word it sent to each target, so that every frame carries a word for every receiver and all of them switch together on the common enable fall.

All timing parameters must be at least 1. A command whose target index is out of range is consumed without any bus activity.

Top module: `tune_bus_master`

## Requirements
- R1: While and after a synchronous reset, `ser_en`, `ser_clk`, `ser_dat` and `done` are low, and `cmd_ready` is high.
- R2: Every frame has exactly 8 rising edges of `ser_clk`. The bit sampled on each rise, in order, comes from the word `{2'b00, cmd_stby, cmd_state[4:0]}`, most significant bit first.
- R3: With `SIMUL=0` there is one data line. Only enable bit `cmd_tgt` (bit i selects target i) rises, and it stays unchanged for the whole frame while all other enable bits stay low.
- R4: With `SIMUL=1` there is one common enable, and data lane i carries the newest word for target i. The command replaces the word of target `cmd_tgt`. Every other lane resends its previous word, which is 8'h00 after reset.
- R5: The enable rises on the clock edge that accepts a command, and the first `ser_clk` rise follows exactly `LEAD_CYC` cycles later.
- R6: `ser_clk` stays high for exactly `HI_CYC` cycles and low for exactly `LO_CYC` cycles between rises. Inside a frame, the data lines change only on the edge where `ser_clk` falls.
- R7: After the last clock fall the enable stays high for exactly `TAIL_CYC` cycles. The enable and the data lines then go low on the same edge, and `ser_clk` is low whenever the enable is low.
- R8: The enable stays low for at least `GAP_CYC` cycles between consecutive frames.
- R9: `done` is high for exactly one cycle, on the edge where the enable falls, and at no other time.
- R10: `cmd_ready` is high only when the block is idle. A command held valid while the block is busy waits, and each accepted in-range command produces exactly one frame.
- R11: A command with `cmd_tgt >= N_TGT` completes the handshake but produces no frame and no `done`, and it leaves the stored per-target words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_tgt | input | TGT_W | Target index |
| cmd_state | input | 5 | Tuning state to program |
| cmd_stby | input | 1 | Standby flag for the target |
| done | output | 1 | One-cycle pulse when a frame ends |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_en | output | EN_W | Enable lines: one per target (SIMUL=0) or one common (SIMUL=1) |
| ser_dat | output | DAT_W | Data lines: one shared (SIMUL=0) or one per target (SIMUL=1) |

## Verification
Call the accepting edge A. The enable rises at A, and the first serial clock rise comes at A+LEAD_CYC. Each later rise follows HI_CYC+LO_CYC cycles after the previous one. The enable falls, with `done` on the same edge, TAIL_CYC cycles after the eighth clock fall. `cmd_ready` returns GAP_CYC cycles after that. The bench monitor samples every output on the falling system clock edge and measures the length of each high and low run against these counts. It rebuilds each frame from the levels seen at the serial clock rises and compares it with the item the driver queued when the command was accepted. Two instances run side by side, one per sharing scheme, with different timing parameters, so that each count is checked at more than one value.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  localparam int WORD_W  = 8;
  localparam int STATE_W = 5;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_HIGH,
    PH_LOW,
    PH_TAIL,
    PH_GAP
  } phase_e;

  // Frame word: two zero bits, the standby flag, then the state, MSB first.
  function automatic logic [WORD_W-1:0] pack_word(input logic stby,
                                                  input logic [STATE_W-1:0] st);
    return {2'b00, stby, st};
  endfunction

  function automatic int max_of5(input int a, input int b, input int c,
                                 input int d, input int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/sbus_word_bank.sv
module sbus_word_bank
  import sbus_pkg::*;
#(
  parameter int N_TGT = 4,
  parameter int SIMUL = 0,
  parameter int TGT_W = 2,
  parameter int EN_W  = 4,
  parameter int DAT_W = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    clear,
  input  logic [TGT_W-1:0]        tgt,
  input  logic [WORD_W-1:0]       word,
  output logic [EN_W-1:0]         en_q,
  output logic [DAT_W*WORD_W-1:0] lane_words
);

  logic [EN_W-1:0] en_sel;

  generate
    if (SIMUL != 0) begin : g_simul
      // One stored word per target; every frame resends all of them.
      logic [WORD_W-1:0] shadow [N_TGT];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < N_TGT; i++) shadow[i] <= '0;
        end else if (load) begin
          for (int i = 0; i < N_TGT; i++)
            if (tgt == TGT_W'(i)) shadow[i] <= word;
        end
      end

      always_comb begin
        for (int i = 0; i < N_TGT; i++)
          lane_words[i*WORD_W +: WORD_W] = (load && tgt == TGT_W'(i)) ? word : shadow[i];
      end

      assign en_sel = '1;
    end else begin : g_seq
      // One shared data lane; enable decoded from the target index.
      assign lane_words = word;

      always_comb begin
        for (int i = 0; i < EN_W; i++) en_sel[i] = (tgt == TGT_W'(i));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (load)  en_q <= en_sel;
    else if (clear) en_q <= '0;
  end

endmodule

// File: rtl/sbus_lane_shift.sv
module sbus_lane_shift
  import sbus_pkg::*;
#(
  parameter int DAT_W = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    shift,
  input  logic                    clear,
  input  logic [DAT_W*WORD_W-1:0] words,
  output logic [DAT_W-1:0]        dat
);

  generate
    for (genvar l = 0; l < DAT_W; l++) begin : g_lane
      logic [WORD_W-1:0] sh;

      always_ff @(posedge clk) begin
        if (rst)        sh <= '0;
        else if (load)  sh <= words[l*WORD_W +: WORD_W];
        else if (shift) sh <= {sh[WORD_W-2:0], 1'b0};
        else if (clear) sh <= '0;
      end

      assign dat[l] = sh[WORD_W-1];
    end
  endgenerate

endmodule

// File: rtl/sbus_frame_fsm.sv
module sbus_frame_fsm
  import sbus_pkg::*;
#(
  parameter int LEAD_CYC = 1,
  parameter int HI_CYC   = 1,
  parameter int LO_CYC   = 1,
  parameter int TAIL_CYC = 1,
  parameter int GAP_CYC  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ready,
  output logic bus_clk,
  output logic done,
  output logic shift_o,
  output logic clear_o
);

  localparam int MAX_C = max_of5(LEAD_CYC, HI_CYC, LO_CYC, TAIL_CYC, GAP_CYC);
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam int BIT_W = $clog2(WORD_W);

  phase_e           ph;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bits;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);
  assign ready    = (ph == PH_IDLE);
  assign shift_o  = (ph == PH_HIGH) && cnt_zero && (bits != '0);
  assign clear_o  = (ph == PH_TAIL) && cnt_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      bits    <= '0;
      bus_clk <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ph   <= PH_LEAD;
            cnt  <= CNT_W'(LEAD_CYC - 1);
            bits <= BIT_W'(WORD_W - 1);
          end
        end
        PH_LEAD: begin
          if (cnt_zero) begin
            ph      <= PH_HIGH;
            bus_clk <= 1'b1;
            cnt     <= CNT_W'(HI_CYC - 1);
          end else cnt <= cnt - CNT_W'(1);
        end
        PH_HIGH: begin
          if (cnt_zero) begin
            bus_clk <= 1'b0;
            if (bits == '0) begin
              ph  <= PH_TAIL;
              cnt <= CNT_W'(TAIL_CYC - 1);
            end else begin
              ph   <= PH_LOW;
              bits <= bits - BIT_W'(1);
              cnt  <= CNT_W'(LO_CYC - 1);
            end
          end else cnt <= cnt - CNT_W'(1);
        end
        PH_LOW: begin
          if (cnt_zero) begin
            ph      <= PH_HIGH;
            bus_clk <= 1'b1;
            cnt     <= CNT_W'(HI_CYC - 1);
          end else cnt <= cnt - CNT_W'(1);
        end
        PH_TAIL: begin
          if (cnt_zero) begin
            ph   <= PH_GAP;
            done <= 1'b1;
            cnt  <= CNT_W'(GAP_CYC - 1);
          end else cnt <= cnt - CNT_W'(1);
        end
        PH_GAP: begin
          if (cnt_zero) ph <= PH_IDLE;
          else          cnt <= cnt - CNT_W'(1);
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tune_bus_master.sv
module tune_bus_master
  import sbus_pkg::*;
#(
  parameter int N_TGT    = 4,
  parameter int SIMUL    = 0,
  parameter int LEAD_CYC = 1,
  parameter int HI_CYC   = 1,
  parameter int LO_CYC   = 1,
  parameter int TAIL_CYC = 1,
  parameter int GAP_CYC  = 2,
  localparam int TGT_W   = (N_TGT > 1) ? $clog2(N_TGT) : 1,
  localparam int EN_W    = (SIMUL != 0) ? 1 : N_TGT,
  localparam int DAT_W   = (SIMUL != 0) ? N_TGT : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [TGT_W-1:0]   cmd_tgt,
  input  logic [STATE_W-1:0] cmd_state,
  input  logic               cmd_stby,
  output logic               done,
  output logic               ser_clk,
  output logic [EN_W-1:0]    ser_en,
  output logic [DAT_W-1:0]   ser_dat
);

  logic                    fsm_ready;
  logic                    tgt_ok;
  logic                    launch;
  logic                    shift_p;
  logic                    clear_p;
  logic [WORD_W-1:0]       word;
  logic [DAT_W*WORD_W-1:0] lane_words;

  assign tgt_ok    = (32'(cmd_tgt) < N_TGT);
  assign launch    = cmd_valid && fsm_ready && tgt_ok;
  assign cmd_ready = fsm_ready;
  assign word      = pack_word(cmd_stby, cmd_state);

  sbus_frame_fsm #(
    .LEAD_CYC(LEAD_CYC),
    .HI_CYC  (HI_CYC),
    .LO_CYC  (LO_CYC),
    .TAIL_CYC(TAIL_CYC),
    .GAP_CYC (GAP_CYC)
  ) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .start  (launch),
    .ready  (fsm_ready),
    .bus_clk(ser_clk),
    .done   (done),
    .shift_o(shift_p),
    .clear_o(clear_p)
  );

  sbus_word_bank #(
    .N_TGT(N_TGT),
    .SIMUL(SIMUL),
    .TGT_W(TGT_W),
    .EN_W (EN_W),
    .DAT_W(DAT_W)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .load      (launch),
    .clear     (clear_p),
    .tgt       (cmd_tgt),
    .word      (word),
    .en_q      (ser_en),
    .lane_words(lane_words)
  );

  sbus_lane_shift #(
    .DAT_W(DAT_W)
  ) u_lanes (
    .clk  (clk),
    .rst  (rst),
    .load (launch),
    .shift(shift_p),
    .clear(clear_p),
    .words(lane_words),
    .dat  (ser_dat)
  );

endmodule

// File: rtl/tune_bus_master_chk.sv
module tune_bus_master_chk #(
  parameter int N_TGT = 4,
  parameter int TGT_W = 2,
  parameter int EN_W  = 4,
  parameter int DAT_W = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [TGT_W-1:0] cmd_tgt,
  input logic             done,
  input logic             ser_clk,
  input logic [EN_W-1:0]  ser_en,
  input logic [DAT_W-1:0] ser_dat
);

  logic en_any;
  logic bad_tgt;
  assign en_any  = |ser_en;
  assign bad_tgt = !(32'(cmd_tgt) < N_TGT);

  AST_CLK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    !en_any |-> !ser_clk); // R7
  AST_DAT_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !en_any |-> (ser_dat == '0)); // R7
  AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ser_en)); // R3
  AST_EN_HELD: assert property (@(posedge clk) disable iff (rst)
    (en_any && $past(en_any)) |-> $stable(ser_en)); // R3
  AST_DAT_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_dat)); // R6
  AST_DAT_MOVE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (en_any && $past(en_any) && !$stable(ser_dat)) |-> $fell(ser_clk)); // R6
  AST_DONE_ON_EN_FALL: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(en_any)); // R9
  AST_EN_FALL_HAS_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(en_any) |-> done); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    en_any |-> !cmd_ready); // R10
  AST_DROP_BAD_TGT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && bad_tgt) |=> !en_any); // R11

endmodule

bind tune_bus_master tune_bus_master_chk #(
  .N_TGT(N_TGT),
  .TGT_W(TGT_W),
  .EN_W (EN_W),
  .DAT_W(DAT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_tgt  (cmd_tgt),
  .done     (done),
  .ser_clk  (ser_clk),
  .ser_en   (ser_en),
  .ser_dat  (ser_dat)
);

// File: tb/tune_bus_master_tb_mon.sv
module tune_bus_master_tb_mon #(
  parameter string TAG      = "seq",
  parameter int    SIMUL    = 0,
  parameter int    LEAD_CYC = 1,
  parameter int    HI_CYC   = 1,
  parameter int    LO_CYC   = 1,
  parameter int    TAIL_CYC = 1,
  parameter int    GAP_CYC  = 2,
  parameter int    EN_W     = 4,
  parameter int    DAT_W    = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_ready,
  input logic             done,
  input logic             ser_clk,
  input logic [EN_W-1:0]  ser_en,
  input logic [DAT_W-1:0] ser_dat
);

  int checks = 0;
  int fails  = 0;
  int frames = 0;

  logic [EN_W-1:0]    q_en[$];
  logic [DAT_W*8-1:0] q_w[$];

  function automatic void push(input logic [EN_W-1:0] e, input logic [DAT_W*8-1:0] w);
    q_en.push_back(e);
    q_w.push_back(w);
  endfunction

  function automatic void chk(input bit ok, input string req, input string what,
                              input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] %s: actual=%0h expected=%0h", req, TAG, what, act, exp);
    end
  endfunction

  logic               p_en, p_clk;
  logic [DAT_W-1:0]   p_dat;
  int                 lead, hi_run, lo_run, rises, gap;
  bit                 seen;
  logic [EN_W-1:0]    en_cap;
  logic [DAT_W*8-1:0] cap;

  always @(negedge clk) begin : sample
    logic               en_now;
    logic [EN_W-1:0]    e_exp;
    logic [DAT_W*8-1:0] w_exp;
    en_now = |ser_en;
    if (rst) begin
      p_en = 1'b0; p_clk = 1'b0; p_dat = '0;
      rises = 0; seen = 1'b0; gap = 0; lead = 0; hi_run = 0; lo_run = 0;
    end else begin
      if (en_now) begin
        if (!p_en) begin
          if (seen) chk(gap >= GAP_CYC, "R8", "enable low gap", gap, GAP_CYC);
          chk($countones(ser_en) == 1, (SIMUL != 0) ? "R4" : "R3", "one enable raised",
              ser_en, 1);
          en_cap = ser_en;
          lead = 0; rises = 0; cap = '0;
        end else begin
          chk(ser_en == en_cap, "R3", "enable stable in frame", ser_en, en_cap);
          if (ser_dat != p_dat && !(p_clk && !ser_clk))
            chk(1'b0, "R6", "data moved away from clock fall", ser_dat, p_dat);
        end
        chk(!cmd_ready, "R10", "ready low while enabled", cmd_ready, 0);
        chk(!done, "R9", "no done inside frame", done, 0);
        if (ser_clk && !p_clk) begin
          rises++;
          if (rises == 1) chk(lead == LEAD_CYC, "R5", "lead cycles", lead, LEAD_CYC);
          else            chk(lo_run == LO_CYC, "R6", "clock low cycles", lo_run, LO_CYC);
          for (int l = 0; l < DAT_W; l++) cap[l*8 +: 8] = {cap[l*8 +: 7], ser_dat[l]};
          hi_run = 1;
        end else if (ser_clk) begin
          hi_run++;
        end else if (p_clk) begin
          chk(hi_run == HI_CYC, "R6", "clock high cycles", hi_run, HI_CYC);
          lo_run = 1;
        end else if (rises == 0) begin
          lead++;
        end else begin
          lo_run++;
        end
      end else begin
        if (p_en) begin
          frames++;
          chk(done, "R9", "done on enable fall", done, 1);
          chk(rises == 8, "R2", "clock rises per frame", rises, 8);
          chk(lo_run == TAIL_CYC, "R7", "tail cycles", lo_run, TAIL_CYC);
          chk(ser_dat == '0, "R7", "data cleared at enable fall", ser_dat, 0);
          if (q_en.size() == 0) begin
            chk(1'b0, "R10", "frame without accepted command", frames, 0);
          end else begin
            e_exp = q_en.pop_front();
            w_exp = q_w.pop_front();
            chk(en_cap == e_exp, (SIMUL != 0) ? "R4" : "R3", "enable lines", en_cap, e_exp);
            chk(cap == w_exp, (SIMUL != 0) ? "R4" : "R2", "frame words", cap, w_exp);
          end
          seen = 1'b1;
          gap = 1;
        end else begin
          chk(!done, "R9", "no done while idle", done, 0);
          gap++;
        end
        chk(!ser_clk, "R7", "clock low while disabled", ser_clk, 0);
      end
      p_en = en_now; p_clk = ser_clk; p_dat = ser_dat;
    end
  end

endmodule

// File: tb/tune_bus_master_tb_top.sv
`timescale 1ns/1ps
module tune_bus_master_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  // Sequential-scheme instance (defaults).
  logic       s_valid = 1'b0, s_ready, s_stby = 1'b0, s_done, s_clk;
  logic [1:0] s_tgt = '0;
  logic [4:0] s_state = '0;
  logic [3:0] s_en;
  logic [0:0] s_dat;

  tune_bus_master dut_i (
    .clk(clk), .rst(rst), .cmd_valid(s_valid), .cmd_ready(s_ready),
    .cmd_tgt(s_tgt), .cmd_state(s_state), .cmd_stby(s_stby), .done(s_done),
    .ser_clk(s_clk), .ser_en(s_en), .ser_dat(s_dat)
  );

  tune_bus_master_tb_mon #(.TAG("seq"), .SIMUL(0), .EN_W(4), .DAT_W(1)) mon_seq (
    .clk(clk), .rst(rst), .cmd_ready(s_ready), .done(s_done),
    .ser_clk(s_clk), .ser_en(s_en), .ser_dat(s_dat)
  );

  // Simultaneous-scheme instance, three targets, stretched timing.
  logic       m_valid = 1'b0, m_ready, m_stby = 1'b0, m_done, m_clk;
  logic [1:0] m_tgt = '0;
  logic [4:0] m_state = '0;
  logic [0:0] m_en;
  logic [2:0] m_dat;

  tune_bus_master #(
    .N_TGT(3), .SIMUL(1), .LEAD_CYC(2), .HI_CYC(2), .LO_CYC(3), .TAIL_CYC(2), .GAP_CYC(3)
  ) dut_sim_i (
    .clk(clk), .rst(rst), .cmd_valid(m_valid), .cmd_ready(m_ready),
    .cmd_tgt(m_tgt), .cmd_state(m_state), .cmd_stby(m_stby), .done(m_done),
    .ser_clk(m_clk), .ser_en(m_en), .ser_dat(m_dat)
  );

  tune_bus_master_tb_mon #(
    .TAG("sim"), .SIMUL(1), .LEAD_CYC(2), .HI_CYC(2), .LO_CYC(3), .TAIL_CYC(2),
    .GAP_CYC(3), .EN_W(1), .DAT_W(3)
  ) mon_sim (
    .clk(clk), .rst(rst), .cmd_ready(m_ready), .done(m_done),
    .ser_clk(m_clk), .ser_en(m_en), .ser_dat(m_dat)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  int seq_sent = 0;
  int sim_sent = 0;
  logic [7:0] sh [3] = '{8'h00, 8'h00, 8'h00};

  function automatic void tchk(input bit ok, input string req, input string what,
                               input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [top] %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d",
             checks + mon_seq.checks + mon_sim.checks,
             fails + mon_seq.fails + mon_sim.fails);
  endtask

  // Driver: called at a falling edge; holds valid until the design is ready.
  task automatic send_seq(input logic [1:0] t, input logic [4:0] s, input logic b);
    s_tgt = t; s_state = s; s_stby = b; s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    mon_seq.push(4'b0001 << t, {2'b00, b, s});
    seq_sent++;
  endtask

  task automatic send_sim(input logic [1:0] t, input logic [4:0] s, input logic b);
    m_tgt = t; m_state = s; m_stby = b; m_valid = 1'b1;
    while (!m_ready) @(negedge clk);
    @(negedge clk);
    m_valid = 1'b0;
    if (t < 2'd3) begin
      sh[t] = {2'b00, b, s};
      mon_sim.push(1'b1, {sh[2], sh[1], sh[0]});
      sim_sent++;
    end
  endtask

  task automatic run_seq();
    send_seq(2'd0, 5'd0, 1'b0);
    send_seq(2'd3, 5'd31, 1'b1);
    send_seq(2'd1, 5'h15, 1'b0);
    send_seq(2'd2, 5'h0A, 1'b1);
    send_seq(2'd0, 5'h1F, 1'b0);
    send_seq(2'd3, 5'd0, 1'b1);
  endtask

  task automatic run_sim();
    int f0;
    int bad;
    send_sim(2'd1, 5'd5, 1'b0);
    send_sim(2'd0, 5'd31, 1'b1);
    while (m_en != '0 || mon_sim.q_en.size() != 0) @(negedge clk);
    f0  = mon_sim.frames;
    bad = 0;
    send_sim(2'd3, 5'h1C, 1'b1);  // R11: index out of range
    repeat (80) begin
      @(negedge clk);
      if (m_en != '0 || m_done) bad++;
    end
    tchk(bad == 0, "R11", "bus quiet after bad index", bad, 0);
    tchk(mon_sim.frames == f0, "R11", "no frame for bad index", mon_sim.frames, f0);
    send_sim(2'd2, 5'h12, 1'b0);   // earlier words must still be intact (R11, R4)
    send_sim(2'd1, 5'h0B, 1'b1);
    send_sim(2'd0, 5'd0, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state of both instances
    tchk(s_en == '0 && s_clk == 1'b0 && s_dat == '0, "R1", "seq bus idle in reset",
         {s_en, s_clk, s_dat}, 0);
    tchk(s_ready && !s_done, "R1", "seq ready, no done", {s_ready, s_done}, 2);
    tchk(m_en == '0 && m_clk == 1'b0 && m_dat == '0, "R1", "sim bus idle in reset",
         {m_en, m_clk, m_dat}, 0);
    tchk(m_ready && !m_done, "R1", "sim ready, no done", {m_ready, m_done}, 2);
    rst = 1'b0;
    @(negedge clk);
    tchk(s_ready && s_en == '0, "R1", "seq idle after reset", {s_ready, s_en}, 5'h10);
    fork
      run_seq();
      run_sim();
    join
    while (s_en != '0 || m_en != '0 || mon_seq.q_en.size() != 0 || mon_sim.q_en.size() != 0)
      @(negedge clk);
    repeat (10) @(negedge clk);
    tchk(mon_seq.frames == seq_sent, "R10", "seq one frame per command", mon_seq.frames, seq_sent);
    tchk(mon_sim.frames == sim_sent, "R10", "sim one frame per command", mon_sim.frames, sim_sent);
    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
      $finish;
    end
  end

endmodule